// File: doc/BRIEF.md
# Memory-Mapped SPI Byte Exchanger

This block is an SPI master that a processor drives through two memory locations. A bus write to the data location stores the next byte to send. A bus write of any value to the adjacent start location launches one full-duplex exchange. During the exchange the stored byte goes out on MOSI and a byte comes in from MISO. A later read of the data location returns the byte that was received. Chip select comes from elsewhere, and the block has no knowledge of any card protocol.

The shifter runs from its own oscillator clock, which is not tied to the bus clock. The start request crosses into the oscillator domain through a synchroniser, and an edge detector turns it into a pulse. SCLK is the oscillator divided by `CLK_DIV`. With a 16 MHz oscillator and the default divider of 2, SCLK runs at 8 MHz and a whole byte takes 16 oscillator cycles. That is short enough to finish inside a slow processor's memory cycle.

Transfers are MSB first in SPI mode 0. SCLK idles low, MISO is sampled on each rising edge, and MOSI changes only on falling edges. The received byte is copied to the readable register only when the last bit completes.

Top module: `spi_xchg_top`

## Requirements
- R1: After reset, SCLK is low, MOSI is high, and a read of the data location returns 0x00 with `bus_rvalid` high.
- R2: A write to `DATA_ADDR` (default 0xEFFB) stores the transmit byte. A write to any address other than `DATA_ADDR` or `START_ADDR` changes neither the transmit byte nor the SPI pins.
- R3: A write of any value to `START_ADDR` (default 0xEFFC) starts one exchange of exactly `BITS` (default 8) rising SCLK edges, after which SCLK stays low.
- R4: MOSI presents the transmit byte most significant bit first. MOSI changes only while SCLK is low and is stable while SCLK is high.
- R5: MISO is sampled on each rising SCLK edge, first bit into the most significant position. After the exchange, a read of `DATA_ADDR` returns the sampled byte.
- R6: Successive rising SCLK edges within an exchange are `CLK_DIV` oscillator cycles apart (default 2, i.e. SCLK = oscillator / 2).
- R7: A start request that arrives while an exchange is in progress is ignored. No extra SCLK edges follow, and no second exchange is queued.
- R8: The receive register changes only when an exchange completes. A read during an exchange returns the previous received byte.
- R9: A write to `DATA_ADDR` during an exchange does not alter the bits being shifted. The new byte is sent by the next exchange.
- R10: `bus_rvalid` is high only for a read of `DATA_ADDR`. In every other cycle `bus_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Processor bus clock |
| osc_clk | input | 1 | Oscillator clock for the shifter |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_addr | input | ADDR_W (16) | Bus address |
| bus_wr | input | 1 | Write strobe, one bus cycle |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | BITS (8) | Write data |
| bus_rdata | output | BITS (8) | Received byte on a data-location read, else zero |
| bus_rvalid | output | 1 | High when the current read hits the data location |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data out, idles high |
| spi_miso | input | 1 | Serial data in |

## Verification
Two functions can coincide: the processor can write the next transmit byte, or read the data location, while the shifter is still clocking out the current byte. The bench provokes this by issuing the write or read a few oscillator cycles after a start. At that point the exchange is known to be mid-flight, because the bench counts SCLK edges. The bench then judges the result at the pins and at the bus. A bench-side slave model must have received the old byte. The mid-transfer read must return the previous exchange's byte. A follow-up exchange must carry the new byte. A second start written during the same window must add no SCLK edges.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;

   // Shifter phase: idle, SCLK low half, SCLK high half
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_LOW  = 2'd1,
      PH_HIGH = 2'd2
   } phase_t;

   // Width of a counter that must hold values 0..n-1 (at least one bit)
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/spi_xchg_sync.sv
module spi_xchg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_xchg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= 1'b0;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/spi_xchg_regs.sv
module spi_xchg_regs #(
   parameter int unsigned     ADDR_W     = 16,
   parameter int unsigned     BITS       = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR  = 16'hEFFB,
   parameter logic [ADDR_W-1:0] START_ADDR = 16'hEFFC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BITS-1:0]   wdata,
   input  logic [BITS-1:0]   rx_byte,
   output logic [BITS-1:0]   tx_byte,
   output logic              start_tgl,
   output logic [BITS-1:0]   rdata,
   output logic              rvalid
);

   if (DATA_ADDR == START_ADDR) begin : g_bad_map
      $error("spi_xchg_regs: data and start locations must differ");
   end

   logic hit_data;
   logic hit_start;

   assign hit_data  = (addr == DATA_ADDR);
   assign hit_start = (addr == START_ADDR);

   // Transmit holding register: stays quiet while the shifter copies it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                tx_byte <= '0;
      else if (wr && hit_data)   tx_byte <= wdata;
   end

   // Start request as a level toggle, safe to pass through a synchroniser
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                start_tgl <= 1'b0;
      else if (wr && hit_start)  start_tgl <= ~start_tgl;
   end

   assign rvalid = rd && hit_data;
   assign rdata  = rvalid ? rx_byte : '0;

endmodule

// File: rtl/spi_xchg_shifter.sv
module spi_xchg_shifter
   import spi_xchg_pkg::*;
#(
   parameter int unsigned BITS      = 8,
   parameter int unsigned CLK_DIV   = 2,
   parameter logic        IDLE_MOSI = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_lvl,
   input  logic [BITS-1:0] tx_byte,
   input  logic            miso,
   output logic            sclk,
   output logic            mosi,
   output logic            busy,
   output logic            start_pulse,
   output logic [BITS-1:0] rx_byte
);

   localparam int unsigned HALF  = CLK_DIV / 2;
   localparam int unsigned DIV_W = cnt_width(HALF);
   localparam int unsigned BIT_W = cnt_width(BITS);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("spi_xchg_shifter: CLK_DIV must be even and at least 2");
   end
   if (BITS < 2) begin : g_bad_bits
      $error("spi_xchg_shifter: BITS must be at least 2");
   end

   phase_t            phase;
   logic [DIV_W-1:0]  div;
   logic [BIT_W-1:0]  bitn;
   logic [BITS-1:0]   shreg;
   logic              samp;
   logic              start_d;
   logic              half_done;

   // Edge detect on the synchronised toggle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) start_d <= 1'b0;
      else        start_d <= start_lvl;
   end

   assign start_pulse = start_lvl ^ start_d;
   assign half_done   = (div == DIV_LAST);
   assign busy        = (phase != PH_IDLE);
   assign mosi        = busy ? shreg[BITS-1] : IDLE_MOSI;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         div     <= '0;
         bitn    <= '0;
         shreg   <= '0;
         samp    <= 1'b0;
         sclk    <= 1'b0;
         rx_byte <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               // a pulse here starts; a pulse while busy falls on other arms
               if (start_pulse) begin
                  phase <= PH_LOW;
                  shreg <= tx_byte;
                  div   <= '0;
                  bitn  <= '0;
                  sclk  <= 1'b0;
               end
            end
            PH_LOW: begin
               if (half_done) begin
                  div   <= '0;
                  sclk  <= 1'b1;
                  samp  <= miso;
                  phase <= PH_HIGH;
               end else begin
                  div <= div + 1'b1;
               end
            end
            PH_HIGH: begin
               if (half_done) begin
                  div   <= '0;
                  sclk  <= 1'b0;
                  shreg <= {shreg[BITS-2:0], samp};
                  if (bitn == BIT_LAST) begin
                     phase   <= PH_IDLE;
                     rx_byte <= {shreg[BITS-2:0], samp};
                  end else begin
                     bitn  <= bitn + 1'b1;
                     phase <= PH_LOW;
                  end
               end else begin
                  div <= div + 1'b1;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/spi_xchg_top.sv
module spi_xchg_top #(
   parameter int unsigned       ADDR_W      = 16,
   parameter int unsigned       BITS        = 8,
   parameter logic [ADDR_W-1:0] DATA_ADDR   = 16'hEFFB,
   parameter logic [ADDR_W-1:0] START_ADDR  = 16'hEFFC,
   parameter int unsigned       CLK_DIV     = 2,
   parameter int unsigned       SYNC_STAGES = 2
) (
   input  logic              bus_clk,
   input  logic              osc_clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [BITS-1:0]   bus_wdata,
   output logic [BITS-1:0]   bus_rdata,
   output logic              bus_rvalid,
   output logic              spi_sclk,
   output logic              spi_mosi,
   input  logic              spi_miso
);

   logic [BITS-1:0] tx_byte;
   logic [BITS-1:0] rx_byte;
   logic            start_tgl;
   logic            start_lvl;
   logic            start_pulse;
   logic            busy;

   spi_xchg_regs #(
      .ADDR_W     (ADDR_W),
      .BITS       (BITS),
      .DATA_ADDR  (DATA_ADDR),
      .START_ADDR (START_ADDR)
   ) u_regs (
      .clk       (bus_clk),
      .rst_n     (rst_n),
      .addr      (bus_addr),
      .wr        (bus_wr),
      .rd        (bus_rd),
      .wdata     (bus_wdata),
      .rx_byte   (rx_byte),
      .tx_byte   (tx_byte),
      .start_tgl (start_tgl),
      .rdata     (bus_rdata),
      .rvalid    (bus_rvalid)
   );

   spi_xchg_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (osc_clk),
      .rst_n (rst_n),
      .d     (start_tgl),
      .q     (start_lvl)
   );

   spi_xchg_shifter #(
      .BITS      (BITS),
      .CLK_DIV   (CLK_DIV),
      .IDLE_MOSI (1'b1)
   ) u_shift (
      .clk         (osc_clk),
      .rst_n       (rst_n),
      .start_lvl   (start_lvl),
      .tx_byte     (tx_byte),
      .miso        (spi_miso),
      .sclk        (spi_sclk),
      .mosi        (spi_mosi),
      .busy        (busy),
      .start_pulse (start_pulse),
      .rx_byte     (rx_byte)
   );

endmodule

// File: rtl/spi_xchg_chk.sv
module spi_xchg_chk #(
   parameter int unsigned BITS = 8
) (
   input logic            osc_clk,
   input logic            rst_n,
   input logic            busy,
   input logic            start_pulse,
   input logic            spi_sclk,
   input logic            spi_mosi,
   input logic [BITS-1:0] rx_byte
);

   localparam int unsigned CW = $clog2(BITS) + 2;

   logic          sclk_q;
   logic [CW-1:0] rises;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= spi_sclk;
   end

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n)                      rises <= '0;
      else if (!busy)                  rises <= '0;
      else if (spi_sclk && !sclk_q)    rises <= rises + 1'b1;
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !busy |-> !spi_sclk); // R3

   AST_MOSI_STABLE_HIGH: assert property (@(posedge osc_clk) disable iff (!rst_n)
      spi_sclk |-> $stable(spi_mosi)); // R4

   AST_EDGE_COUNT: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $fell(busy) |-> (rises == CW'(BITS))); // R3

   AST_START_ONLY_IDLE: assert property (@(posedge osc_clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start_pulse)); // R7

   AST_RX_AT_END: assert property (@(posedge osc_clk) disable iff (!rst_n)
      !$stable(rx_byte) |-> $fell(busy)); // R8

endmodule

bind spi_xchg_top spi_xchg_chk #(.BITS(BITS)) u_chk (
   .osc_clk     (osc_clk),
   .rst_n       (rst_n),
   .busy        (busy),
   .start_pulse (start_pulse),
   .spi_sclk    (spi_sclk),
   .spi_mosi    (spi_mosi),
   .rx_byte     (rx_byte)
);

// File: tb/sim_spi_xchg_top.sv
`timescale 1ns/1ps
module sim_spi_xchg_top;

   localparam logic [15:0] A_DATA  = 16'hEFFB;
   localparam logic [15:0] A_START = 16'hEFFC;
   localparam int          OSC_HALF = 31;
   localparam int          NVEC = 6;
   // {byte sent by master, byte returned by slave}
   localparam logic [15:0] VEC [NVEC] = '{
      16'hA55A, 16'h0000, 16'hFFFF, 16'h8001, 16'h3CC3, 16'h7E81
   };

   logic        bus_clk = 1'b0;
   logic        osc_clk = 1'b0;
   logic        rst_n   = 1'b0;
   logic [15:0] bus_addr  = '0;
   logic        bus_wr    = 1'b0;
   logic        bus_rd    = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        bus_rvalid;
   logic        spi_sclk;
   logic        spi_mosi;
   logic        spi_miso;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 bus_clk = ~bus_clk;           // 125 MHz bus
   always #(OSC_HALF) osc_clk = ~osc_clk;  // oscillator

   spi_xchg_top u0 (
      .bus_clk    (bus_clk),
      .osc_clk    (osc_clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .bus_rvalid (bus_rvalid),
      .spi_sclk   (spi_sclk),
      .spi_mosi   (spi_mosi),
      .spi_miso   (spi_miso)
   );

   // Slave model: mode 0, MSB first
   logic [7:0] slave_sh = '0;
   logic [7:0] slave_rx = '0;
   int         rises    = 0;
   int         gap_bad  = 0;
   longint     last_rise = 0;

   assign spi_miso = slave_sh[7];

   always @(posedge spi_sclk) begin
      slave_rx = {slave_rx[6:0], spi_mosi};
      if (rises > 0 && ($time - last_rise) != 2 * 2 * OSC_HALF) gap_bad++;
      last_rise = $time;
      rises++;
   end

   always @(negedge spi_sclk) slave_sh = {slave_sh[6:0], 1'b0};

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
      @(negedge bus_clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge bus_clk);
      bus_wr = 1'b0; bus_addr = '0;
   endtask

   task automatic bus_read(input logic [15:0] a, output logic [7:0] d, output logic v);
      @(negedge bus_clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      d = bus_rdata; v = bus_rvalid;
      @(negedge bus_clk);
      bus_rd = 1'b0; bus_addr = '0;
   endtask

   task automatic wait_osc(input int n);
      repeat (n) @(posedge osc_clk);
      @(negedge bus_clk);
   endtask

   task automatic arm_slave(input logic [7:0] b);
      slave_sh = b; slave_rx = '0; rises = 0; gap_bad = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] rd;
      logic       rv;
      #101 rst_n = 1'b1;
      wait_osc(4);

      // R1: reset state
      chk("R1 sclk", spi_sclk, 0);
      chk("R1 mosi", spi_mosi, 1);
      bus_read(A_DATA, rd, rv);
      chk("R1 rdata", rd, 8'h00);
      chk("R1 rvalid", rv, 1);

      // Vector walk: R2 R3 R4 R5 R6
      for (int i = 0; i < NVEC; i++) begin
         arm_slave(VEC[i][7:0]);
         bus_write(A_DATA, VEC[i][15:8]);
         bus_write(A_START, 8'h5A);
         wait_osc(40);
         chk("R3 edges", rises, 8);
         chk("R3 idle sclk", spi_sclk, 0);
         chk("R4 mosi bits", slave_rx, VEC[i][15:8]);
         chk("R6 sclk period", gap_bad, 0);
         bus_read(A_DATA, rd, rv);
         chk("R5 rx byte", rd, VEC[i][7:0]);
      end

      // R2: write to a neighbouring address has no effect
      bus_write(A_DATA, 8'hC4);
      arm_slave(8'h11);
      bus_write(16'hEFFA, 8'h99);
      bus_write(16'hEFFD, 8'h77);
      wait_osc(40);
      chk("R2 no edges from other address", rises, 0);
      chk("R2 mosi idle", spi_mosi, 1);
      bus_write(A_START, 8'h00);
      wait_osc(40);
      chk("R2 tx byte unchanged", slave_rx, 8'hC4);

      // R10: read of other address
      bus_read(A_START, rd, rv);
      chk("R10 rvalid off", rv, 0);
      chk("R10 rdata zero", rd, 8'h00);
      bus_read(16'hEFFA, rd, rv);
      chk("R10 rdata zero other", rd, 8'h00);

      // R7 R8 R9: activity during an exchange
      bus_write(A_DATA, 8'h96);
      arm_slave(8'h3E);
      bus_write(A_START, 8'hFF);
      wait_osc(8);
      chk("R7 mid-transfer", (rises > 0 && rises < 8) ? 1 : 0, 1);
      bus_read(A_DATA, rd, rv);
      chk("R8 old rx during transfer", rd, 8'h11);
      bus_write(A_DATA, 8'h2D);
      bus_write(A_START, 8'h01);
      wait_osc(60);
      chk("R7 no extra edges", rises, 8);
      chk("R9 shifted byte kept", slave_rx, 8'h96);
      bus_read(A_DATA, rd, rv);
      chk("R8 rx after completion", rd, 8'h3E);
      arm_slave(8'hD2);
      bus_write(A_START, 8'h00);
      wait_osc(40);
      chk("R9 new byte next exchange", slave_rx, 8'h2D);
      bus_read(A_DATA, rd, rv);
      chk("R5 rx follow-up", rd, 8'hD2);

      finish_run();
   end

endmodule